// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block guards a single processor core against lockups. Software arms it by writing a configuration word that holds a 16-bit period length and a 2-bit escalation mode. The length is placed in the upper bits of a wider down-counter whose low bits start at zero. A prescaler steps that counter once every `DIVISOR` input clocks. Software keeps the core alive by pulsing `poke`. This reloads the counter and brings the watchdog back to its idle running stage.

If no poke arrives, each expiry of the counter moves the watchdog one stage up the escalation ladder. The first expiry gives an interrupt event, the second a non-maskable interrupt, and the third a soft-reset request. The mode sets how far up the ladder the watchdog may climb. After the highest allowed stage the counter parks at zero. The live count and the stage are always visible at the ports, so software can see how much time remains. A sticky flag records that a reset request came from the watchdog, and software clears it by writing one.

Top module: `esc_watchdog`

## Requirements
- R1: After reset the count is 0, the stage is 0, `irq_o`, `nmi_o` and `rst_req_o` are low, and `wd_flag_o` is 0.
- R2: A reload sets the count to length × 2^FRAC_W, with the low FRAC_W bits zero. While the count is nonzero, the count then drops by exactly one every DIVISOR clocks, and `count_o` shows the live value.
- R3: Each time the count steps from 1 to 0, the stage advances by one. The stage encodings are 0 run, 1 interrupt, 2 NMI and 3 reset. On an advance that does not reach the mode's last stage, the count reloads from the length.
- R4: `irq_o` is high for exactly one cycle, in the cycle after the advance into stage 1. It stays low at all other times.
- R5: `nmi_o` is high while the stage is 2 or 3. It stays high until a poke or a configuration write.
- R6: `rst_req_o` is high for exactly one cycle, in the cycle after the advance into stage 3.
- R7: `wd_flag_o` is set in the same cycle as `rst_req_o`. It stays set until `flag_clr` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R8: The mode value is the highest stage that can be reached: 1 allows the interrupt only, 2 allows up to NMI, and 3 allows the full ladder. When the last allowed stage is reached, the count goes to 0 and stays there.
- R9: The watchdog is disabled when the mode is 0 or the length is 0. While disabled, the count is 0 and the stage is 0, and `poke` has no effect. A configuration write of all zeros disables the watchdog and clears its count and stage.
- R10: When the watchdog is enabled, `poke` reloads the count from the length, clears the prescaler and returns the stage to 0. If a poke and an expiry fall in the same cycle, the poke wins and the stage does not advance.
- R11: A configuration write while the watchdog is running restarts it from stage 0. The count takes the new length, and `nmi_o` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W (16) | Period length written with `cfg_we` |
| cfg_mode | input | 2 | Highest escalation stage, 0 = off |
| poke | input | 1 | Keep-alive: reload count, return to stage 0 |
| flag_clr | input | 1 | Write-one-to-clear for the watchdog reset flag |
| count_o | output | LEN_W+FRAC_W (24) | Live down-counter value |
| stage_o | output | 2 | Current stage (0 run, 1 irq, 2 nmi, 3 reset) |
| irq_o | output | 1 | One-cycle interrupt event at first expiry |
| nmi_o | output | 1 | NMI level while in stage 2 or 3 |
| rst_req_o | output | 1 | One-cycle soft-reset request |
| wd_flag_o | output | 1 | Sticky record of a watchdog reset request |

## Verification
All outputs come from registers, so every input effect shows up in the cycle after the edge that samples it. A config write or poke sets the count, stage and `nmi_o` one cycle later. The count then steps DIVISOR cycles after the prescaler restarts. An expiry shows on `stage_o`, `irq_o` and `rst_req_o` in the cycle after the edge on which the count leaves 1. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge with the same sampled inputs. It compares every output against that model on each falling edge, so every due cycle is checked exactly where it lands. Directed checks then pin down the poke-versus-expiry collision, the mode limits and the disable cases.

// File: rtl/wd_pkg.sv
package wd_pkg;

    // Escalation ladder; numeric order is the escalation order.
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_IRQ = 2'd1,
        ST_NMI = 2'd2,
        ST_RST = 2'd3
    } wd_stage_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/wd_prescale.sv
module wd_prescale #(
    parameter int DIVISOR = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIVISOR > 1) ? $clog2(DIVISOR) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIVISOR - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t st_q, st_d;

    assign tick = run && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Ticks are at least DIVISOR cycles apart, so never back to back.
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/wd_decrement.sv
module wd_decrement #(
    parameter int LEN_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [LEN_W-1:0]        load_len,
    input  logic                    zero,
    input  logic                    step,
    output logic [LEN_W+FRAC_W-1:0] count_o,
    output logic                    expire_o
);
    localparam int CW = LEN_W + FRAC_W;
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] count;
    } dec_t;

    dec_t st_q, st_d;

    assign count_o  = st_q.count;
    assign expire_o = step && (st_q.count == ONE);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.count = {load_len, {FRAC_W{1'b0}}};
        end else if (zero) begin
            st_d.count = '0;
        end else if (step && (st_q.count != '0)) begin
            st_d.count = st_q.count - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Without load, a zero count stays zero.
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) && !load |=> (count_o == '0)); // R8

endmodule

// File: rtl/wd_stage_fsm.sv
module wd_stage_fsm
    import wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              expire,
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_clr,
    output wd_stage_e         stage_o,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic              flag_o,
    output logic              adv_o,
    output logic              last_o
);
    typedef struct packed {
        wd_stage_e stage;
        logic      irq;
        logic      rst;
        logic      flag;
    } fsm_t;

    fsm_t st_q, st_d;
    wd_stage_e nxt_stage;

    assign nxt_stage = wd_stage_e'(st_q.stage + 2'd1);
    assign adv_o     = expire && !restart && (st_q.stage < mode);
    assign last_o    = (nxt_stage == wd_stage_e'(mode));

    assign stage_o   = st_q.stage;
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst;
    assign flag_o    = st_q.flag;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.rst = 1'b0;
        if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        if (restart) begin
            st_d.stage = ST_RUN;
        end else if (adv_o) begin
            st_d.stage = nxt_stage;
            if (nxt_stage == ST_IRQ) begin
                st_d.irq = 1'b1;
            end
            if (nxt_stage == ST_RST) begin
                st_d.rst  = 1'b1;
                st_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage: ST_RUN, irq: 1'b0, rst: 1'b0, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R4
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R6
    AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> flag_o); // R7
    AST_IRQ_AT_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stage_o == ST_IRQ)); // R4

endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
    import wd_pkg::*;
#(
    parameter int DIVISOR = 256,
    parameter int LEN_W   = 16,
    parameter int FRAC_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [LEN_W-1:0]        cfg_len,
    input  logic [1:0]              cfg_mode,
    input  logic                    poke,
    input  logic                    flag_clr,
    output logic [LEN_W+FRAC_W-1:0] count_o,
    output logic [1:0]              stage_o,
    output logic                    irq_o,
    output logic                    nmi_o,
    output logic                    rst_req_o,
    output logic                    wd_flag_o
);
    localparam int CW = LEN_W + FRAC_W;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [MODE_W-1:0] mode;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic          active_q;
    logic          new_active;
    logic          poke_eff;
    logic          restart;
    logic          tick;
    logic          expire;
    logic          adv;
    logic          last;
    logic          cnt_load;
    logic          cnt_zero;
    logic          pre_clear;
    logic          pre_run;
    logic [LEN_W-1:0] load_len;
    logic [CW-1:0] count;
    wd_stage_e     stage;

    // Configuration register
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.len  = cfg_len;
            cfg_d.mode = cfg_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign active_q   = (cfg_q.mode != '0) && (cfg_q.len != '0);
    assign new_active = (cfg_mode != '0) && (cfg_len != '0);
    assign poke_eff   = poke && active_q && !cfg_we;
    assign restart    = cfg_we || poke_eff;

    assign load_len  = cfg_we ? cfg_len : cfg_q.len;
    assign cnt_load  = (cfg_we && new_active) || poke_eff || (adv && !last);
    assign cnt_zero  = (cfg_we && !new_active) || (adv && last);
    assign pre_clear = restart;
    assign pre_run   = active_q && (count != '0) && !restart;

    wd_prescale #(
        .DIVISOR (DIVISOR)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pre_clear),
        .run   (pre_run),
        .tick  (tick)
    );

    wd_decrement #(
        .LEN_W  (LEN_W),
        .FRAC_W (FRAC_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_len (load_len),
        .zero     (cnt_zero),
        .step     (tick),
        .count_o  (count),
        .expire_o (expire)
    );

    wd_stage_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .expire    (expire),
        .mode      (cfg_q.mode),
        .flag_clr  (flag_clr),
        .stage_o   (stage),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o),
        .flag_o    (wd_flag_o),
        .adv_o     (adv),
        .last_o    (last)
    );

    assign count_o = count;
    assign stage_o = stage;
    assign nmi_o   = (stage == ST_NMI) || (stage == ST_RST);

    AST_STAGE_WITHIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_o <= cfg_q.mode); // R8
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (count_o == '0) && (stage_o == 2'd0)); // R9
    AST_POKE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        poke && active_q && !cfg_we |=>
        (count_o == {$past(cfg_q.len), {FRAC_W{1'b0}}}) && (stage_o == 2'd0)); // R10
    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (stage_o == 2'd0) && !nmi_o); // R11

endmodule

// File: tb/sim_esc_watchdog.sv
`timescale 1ns/1ps
module sim_esc_watchdog;
    localparam int DIV   = 4;
    localparam int LW    = 16;
    localparam int FW    = 2;
    localparam int CW    = LW + FW;
    localparam int LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [LW-1:0] cfg_len = '0;
    logic [1:0]    cfg_mode = '0;
    logic          poke = 1'b0;
    logic          flag_clr = 1'b0;
    logic [CW-1:0] count_o;
    logic [1:0]    stage_o;
    logic          irq_o, nmi_o, rst_req_o, wd_flag_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rst_seen = 0;

    // behavioural model state
    int m_len = 0, m_mode = 0, m_pre = 0, m_cnt = 0, m_stage = 0;
    bit m_irq = 0, m_rst = 0, m_flag = 0;

    always #4 clk = ~clk; // 125 MHz

    esc_watchdog #(.DIVISOR(DIV), .LEN_W(LW), .FRAC_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_mode(cfg_mode), .poke(poke), .flag_clr(flag_clr),
        .count_o(count_o), .stage_o(stage_o), .irq_o(irq_o), .nmi_o(nmi_o),
        .rst_req_o(rst_req_o), .wd_flag_o(wd_flag_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // Model steps on the rising edge from the inputs the design samples.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_len = 0; m_mode = 0; m_pre = 0; m_cnt = 0; m_stage = 0;
            m_irq = 0; m_rst = 0; m_flag = 0;
        end else begin
            bit act;
            act = (m_mode != 0) && (m_len != 0);
            m_irq = 0;
            m_rst = 0;
            if (flag_clr) m_flag = 0;
            if (cfg_we) begin
                m_len = cfg_len; m_mode = cfg_mode; m_pre = 0; m_stage = 0;
                m_cnt = ((m_mode != 0) && (m_len != 0)) ? m_len * (1 << FW) : 0;
            end else if (poke && act) begin
                m_pre = 0; m_stage = 0; m_cnt = m_len * (1 << FW);
            end else if (act && m_cnt != 0) begin
                if (m_pre == DIV - 1) begin
                    m_pre = 0;
                    if (m_cnt == 1) begin
                        m_stage++;
                        if (m_stage == 1) m_irq = 1;
                        if (m_stage == 3) begin m_rst = 1; m_flag = 1; end
                        m_cnt = (m_stage < m_mode) ? m_len * (1 << FW) : 0;
                    end else begin
                        m_cnt--;
                    end
                end else begin
                    m_pre++;
                end
            end
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R2 count", int'(count_o), m_cnt);
            chk("R3 stage", int'(stage_o), m_stage);
            chk("R4 irq", int'(irq_o), int'(m_irq));
            chk("R5 nmi", int'(nmi_o), (m_stage >= 2) ? 1 : 0);
            chk("R6 rst_req", int'(rst_req_o), int'(m_rst));
            chk("R7 flag", int'(wd_flag_o), int'(m_flag));
            if (rst_req_o) rst_seen++;
        end
        if (cycles > LIMIT) begin
            errors++;
            $display("FAIL watchdog: got cycle %0d expected below %0d", cycles, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input int len, input int mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_len = LW'(len); cfg_mode = 2'(mode);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_poke();
        @(negedge clk);
        poke = 1'b1;
        @(negedge clk);
        poke = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 stage", int'(stage_o), 0);
        chk("R1 outputs", int'({irq_o, nmi_o, rst_req_o, wd_flag_o}), 0);

        // Full ladder, length 2: period 2*4*4 = 32 cycles
        write_cfg(2, 3);
        chk("R2 reload value", int'(count_o), 8);
        wait_cyc(DIV);
        chk("R2 one step", int'(count_o), 7);
        wait_cyc(3 * 32 + 10);
        chk("R3 final stage", int'(stage_o), 3);
        chk("R8 parked count", int'(count_o), 0);
        chk("R6 one reset pulse", rst_seen, 1);
        chk("R7 flag set", int'(wd_flag_o), 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R7 flag cleared", int'(wd_flag_o), 0);

        // Mode 1 stops at interrupt stage
        write_cfg(3, 1);
        wait_cyc(48 * 3);
        chk("R8 mode1 stage", int'(stage_o), 1);
        chk("R8 mode1 nmi", int'(nmi_o), 0);

        // Mode 2 reaches NMI but never requests reset
        rst_seen = 0;
        write_cfg(1, 2);
        wait_cyc(100);
        chk("R8 mode2 stage", int'(stage_o), 2);
        chk("R8 mode2 no reset", rst_seen, 0);
        chk("R5 nmi held", int'(nmi_o), 1);
        pulse_poke();
        chk("R5 nmi dropped by poke", int'(nmi_o), 0);
        chk("R10 poke reload", int'(count_o), 4);

        // Disable cases
        write_cfg(0, 3);
        pulse_poke();
        chk("R9 zero length count", int'(count_o), 0);
        chk("R9 zero length stage", int'(stage_o), 0);
        write_cfg(5, 0);
        pulse_poke();
        wait_cyc(20);
        chk("R9 mode0 count", int'(count_o), 0);
        write_cfg(0, 0);
        chk("R9 all-zero write", int'(count_o), 0);

        // Poke colliding with the first expiry
        write_cfg(2, 3);
        while (!(m_cnt == 1 && m_pre == DIV - 1)) @(negedge clk);
        poke = 1'b1;
        @(negedge clk);
        poke = 1'b0;
        chk("R10 collision no irq", int'(irq_o), 0);
        chk("R10 collision stage", int'(stage_o), 0);
        chk("R10 collision reload", int'(count_o), 8);

        // Config write during NMI restarts with new length
        wait_cyc(2 * 32 + 5);
        chk("R5 nmi reached", int'(nmi_o), 1);
        write_cfg(3, 3);
        chk("R11 new length", int'(count_o), 12);
        chk("R11 stage restart", int'(stage_o), 0);
        chk("R11 nmi dropped", int'(nmi_o), 0);
        wait_cyc(60);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule